// File: doc/BRIEF.md
# Linked-Channel DMA Scheduler

This block is the control core of a multi-channel DMA engine. Every channel keeps its own transfer descriptor in registers. The descriptor describes a nested transfer. The inner (minor) loop moves a number of data beats. The outer (major) loop counts how many minor loops make up the whole job. Software writes descriptors one 32-bit word at a time through a configuration port and starts channels with a start pulse vector. A channel that finishes a loop can also start another channel, which chains work without software.

One channel runs at a time. An arbiter picks among the pending channels using one of two policies. In fixed-priority mode the highest channel number wins. In round-robin mode the search starts at the channel after the one last granted. Each beat reads one word from the source address and then writes that word to the destination address, over a single request/acknowledge memory port. When a major loop ends, the channel can raise a sticky interrupt bit. It then either restores its addresses and count, or fetches a fresh four-word descriptor from memory (scatter/gather).

Top module: `dma_sched`

## Requirements
- R1: After reset, `mem_req` is low, `irq` is all zeros and no channel is pending.
- R2: Each beat is a read request (`mem_we`=0) at the source address followed by a write request (`mem_we`=1) at the destination address that carries the data just read. A request holds its address, direction and write data until `mem_ack`.
- R3: One activation runs exactly one minor loop of `nbytes` beats. After each read the source address moves by the signed 8-bit source offset. After each write the destination address moves by the signed 8-bit destination offset.
- R4: Each minor loop end decrements the major count. When the count reaches zero without scatter/gather, the source address, destination address and count return to their programmed values.
- R5: A `sw_start` bit marks its channel pending. A start that arrives while that channel is running is kept, and it yields one more minor loop.
- R6: At a minor loop end that does not finish the major loop, an enabled minor link marks its target channel pending.
- R7: At a major loop end, an enabled major link marks its target channel pending, and the minor link does not fire.
- R8: With `arb_rr`=0, the pending channel with the highest number is granted first.
- R9: With `arb_rr`=1, the search for a grant starts at the channel after the last one granted and wraps.
- R10: A major loop end with interrupt enable sets that channel's `irq` bit. The bit stays set until the matching `irq_clr` bit is pulsed. With interrupt enable off, no bit is set.
- R11: With scatter/gather enabled, a major loop end reads four consecutive words from the next-descriptor address and loads them as the channel's new descriptor words 0 to 3.
- R12: Descriptor words, written by `cfg_we` with `cfg_word` and also fetched in this order by R11, are laid out as follows. Word 0 holds source [15:0] and destination [31:16]. Word 1 holds source offset [7:0], destination offset [15:8], beat count [23:16] and major count [31:24]. Word 2 holds minor-link target [3:0], minor-link enable [4], major-link target [11:8], major-link enable [12], interrupt enable [16] and scatter/gather enable [17]. Word 3 holds the next-descriptor address [15:0].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| arb_rr | input | 1 | 1 selects round-robin, 0 selects fixed priority |
| sw_start | input | NCH | Per-channel software start pulses |
| cfg_we | input | 1 | Descriptor word write strobe |
| cfg_ch | input | log2(NCH) | Channel written |
| cfg_word | input | 2 | Descriptor word index |
| cfg_wdata | input | 32 | Descriptor word value |
| irq_clr | input | NCH | Per-channel interrupt clear pulses |
| irq | output | NCH | Sticky completion interrupts |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | 1 for write, 0 for read |
| mem_addr | output | 16 | Word address |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid with `mem_ack` on a read |
| mem_ack | input | 1 | Request accepted this cycle |

## Verification
The checker assumes that memory acknowledges only requests the block has raised. It also assumes that read data is valid in the acknowledge cycle. Descriptors are written only while their channel is neither pending nor running, and every major count used is at least one. The bench programs a channel only after the engine has been quiet for many cycles. It stalls the memory on a fixed pattern so that held requests really occur. It keeps source, destination and descriptor regions apart, so the expected data can be worked out from the initial memory image alone.

// File: rtl/dma_pkg.sv
package dma_pkg;
  localparam int ADDR_W = 16;
  localparam int DATA_W = 32;
  localparam int CNT_W  = 8;
  localparam int OFF_W  = 8;
  localparam int LNK_W  = 4;
  localparam int WORDS  = 4;
  localparam int WIDX_W = $clog2(WORDS);

  typedef enum logic [2:0] {
    S_IDLE, S_SETUP, S_RD, S_WR, S_MINOR, S_SG
  } eng_state_e;
endpackage

// File: rtl/dma_tcd.sv
module dma_tcd
  import dma_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [WIDX_W-1:0] wr_idx,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              adv_src,
  input  logic              adv_dst,
  input  logic              minor_end,
  output logic [ADDR_W-1:0] src,
  output logic [ADDR_W-1:0] dst,
  output logic [CNT_W-1:0]  nbytes,
  output logic [CNT_W-1:0]  citer,
  output logic              ml_en,
  output logic [LNK_W-1:0]  ml_ch,
  output logic              jl_en,
  output logic [LNK_W-1:0]  jl_ch,
  output logic              int_en,
  output logic              sg_en,
  output logic [ADDR_W-1:0] nxt
);
  logic [ADDR_W-1:0] src_q, src_n, dst_q, dst_n, src0_q, src0_n, dst0_q, dst0_n;
  logic [OFF_W-1:0]  soff_q, soff_n, doff_q, doff_n;
  logic [CNT_W-1:0]  nb_q, nb_n, cit_q, cit_n, bit_q, bit_n;
  logic [17:0]       fl_q, fl_n;
  logic [ADDR_W-1:0] nxt_q, nxt_n;
  logic              upd;
  logic [DATA_W-1:0] unused_wdata;

  assign upd = wr_en | adv_src | adv_dst | minor_end;
  assign unused_wdata = wr_data;

  always_comb begin
    src_n = src_q;  dst_n = dst_q;  src0_n = src0_q; dst0_n = dst0_q;
    soff_n = soff_q; doff_n = doff_q; nb_n = nb_q; cit_n = cit_q; bit_n = bit_q;
    fl_n = fl_q; nxt_n = nxt_q;
    if (adv_src) src_n = src_q + {{(ADDR_W-OFF_W){soff_q[OFF_W-1]}}, soff_q};
    if (adv_dst) dst_n = dst_q + {{(ADDR_W-OFF_W){doff_q[OFF_W-1]}}, doff_q};
    if (minor_end) begin
      if (cit_q == CNT_W'(1)) begin
        cit_n = bit_q;
        if (!fl_q[17]) begin
          src_n = src0_q;
          dst_n = dst0_q;
        end
      end else begin
        cit_n = cit_q - CNT_W'(1);
      end
    end
    if (wr_en) begin
      case (wr_idx)
        2'd0: begin
          src_n = wr_data[15:0];  src0_n = wr_data[15:0];
          dst_n = wr_data[31:16]; dst0_n = wr_data[31:16];
        end
        2'd1: begin
          soff_n = wr_data[7:0];  doff_n = wr_data[15:8];
          nb_n   = wr_data[23:16];
          cit_n  = wr_data[31:24]; bit_n = wr_data[31:24];
        end
        2'd2:    fl_n  = wr_data[17:0];
        default: nxt_n = wr_data[15:0];
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_q <= '0; dst_q <= '0; src0_q <= '0; dst0_q <= '0;
      soff_q <= '0; doff_q <= '0; nb_q <= '0; cit_q <= '0; bit_q <= '0;
      fl_q <= '0; nxt_q <= '0;
    end else if (upd) begin
      src_q <= src_n; dst_q <= dst_n; src0_q <= src0_n; dst0_q <= dst0_n;
      soff_q <= soff_n; doff_q <= doff_n; nb_q <= nb_n; cit_q <= cit_n; bit_q <= bit_n;
      fl_q <= fl_n; nxt_q <= nxt_n;
    end
  end

  assign src    = src_q;
  assign dst    = dst_q;
  assign nbytes = nb_q;
  assign citer  = cit_q;
  assign ml_ch  = fl_q[3:0];
  assign ml_en  = fl_q[4];
  assign jl_ch  = fl_q[11:8];
  assign jl_en  = fl_q[12];
  assign int_en = fl_q[16];
  assign sg_en  = fl_q[17];
  assign nxt    = nxt_q;
endmodule

// File: rtl/dma_arbiter.sv
module dma_arbiter #(
  parameter int NCH = 16,
  localparam int CHW = $clog2(NCH)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] req,
  input  logic           rr_mode,
  input  logic           take,
  output logic           gnt_vld,
  output logic [CHW-1:0] gnt_idx
);
  logic [CHW-1:0] last_q, fix_idx, rr_idx;

  always_comb begin
    fix_idx = '0;
    for (int i = 0; i < NCH; i++)
      if (req[i]) fix_idx = CHW'(i);
  end

  always_comb begin
    rr_idx = '0;
    for (int k = NCH; k >= 1; k--) begin
      if (req[(int'(last_q) + k) % NCH]) rr_idx = CHW'((int'(last_q) + k) % NCH);
    end
  end

  assign gnt_vld = |req;
  assign gnt_idx = rr_mode ? rr_idx : fix_idx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    last_q <= '0;
    else if (take) last_q <= gnt_idx;
  end
endmodule

// File: rtl/dma_engine.sv
module dma_engine
  import dma_pkg::*;
#(
  parameter int NCH = 16,
  localparam int CHW = $clog2(NCH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              gnt_vld,
  input  logic [CHW-1:0]    gnt_idx,
  output logic              take,
  output logic [CHW-1:0]    cur,
  input  logic [ADDR_W-1:0] c_src,
  input  logic [ADDR_W-1:0] c_dst,
  input  logic [CNT_W-1:0]  c_nbytes,
  input  logic [CNT_W-1:0]  c_citer,
  input  logic              c_ml_en,
  input  logic [LNK_W-1:0]  c_ml_ch,
  input  logic              c_jl_en,
  input  logic [LNK_W-1:0]  c_jl_ch,
  input  logic              c_int_en,
  input  logic              c_sg_en,
  input  logic [ADDR_W-1:0] c_nxt,
  output logic              adv_src,
  output logic              adv_dst,
  output logic              minor_end,
  output logic              link_vld,
  output logic [LNK_W-1:0]  link_ch,
  output logic              irq_set,
  output logic              sg_wr,
  output logic [WIDX_W-1:0] sg_idx,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata,
  input  logic              mem_ack
);
  eng_state_e        st_q, st_n;
  logic [CHW-1:0]    cur_q, cur_n;
  logic [CNT_W-1:0]  bc_q, bc_n;
  logic [DATA_W-1:0] dat_q, dat_n;
  logic [WIDX_W-1:0] wi_q, wi_n;

  always_comb begin
    st_n = st_q; cur_n = cur_q; bc_n = bc_q; dat_n = dat_q; wi_n = wi_q;
    take = 1'b0; adv_src = 1'b0; adv_dst = 1'b0; minor_end = 1'b0;
    link_vld = 1'b0; link_ch = '0; irq_set = 1'b0; sg_wr = 1'b0;
    mem_req = 1'b0; mem_we = 1'b0; mem_addr = '0; mem_wdata = '0;
    case (st_q)
      S_IDLE: if (gnt_vld) begin
        take = 1'b1; cur_n = gnt_idx; st_n = S_SETUP;
      end
      S_SETUP: begin
        bc_n = c_nbytes;
        st_n = (c_nbytes == '0) ? S_MINOR : S_RD;
      end
      S_RD: begin
        mem_req = 1'b1; mem_addr = c_src;
        if (mem_ack) begin
          dat_n = mem_rdata; adv_src = 1'b1; st_n = S_WR;
        end
      end
      S_WR: begin
        mem_req = 1'b1; mem_we = 1'b1; mem_addr = c_dst; mem_wdata = dat_q;
        if (mem_ack) begin
          adv_dst = 1'b1; bc_n = bc_q - CNT_W'(1);
          st_n = (bc_q == CNT_W'(1)) ? S_MINOR : S_RD;
        end
      end
      S_MINOR: begin
        minor_end = 1'b1;
        if (c_citer == CNT_W'(1)) begin
          irq_set  = c_int_en;
          link_vld = c_jl_en;
          link_ch  = c_jl_ch;
          wi_n     = '0;
          st_n     = c_sg_en ? S_SG : S_IDLE;
        end else begin
          link_vld = c_ml_en;
          link_ch  = c_ml_ch;
          st_n     = S_IDLE;
        end
      end
      S_SG: begin
        mem_req = 1'b1; mem_addr = c_nxt + ADDR_W'(wi_q);
        if (mem_ack) begin
          sg_wr = 1'b1; wi_n = wi_q + WIDX_W'(1);
          if (wi_q == WIDX_W'(WORDS-1)) st_n = S_IDLE;
        end
      end
      default: st_n = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= S_IDLE; cur_q <= '0; bc_q <= '0; dat_q <= '0; wi_q <= '0;
    end else begin
      st_q <= st_n; cur_q <= cur_n; bc_q <= bc_n; dat_q <= dat_n; wi_q <= wi_n;
    end
  end

  assign cur    = cur_q;
  assign sg_idx = wi_q;
endmodule

// File: rtl/dma_sched.sv
module dma_sched
  import dma_pkg::*;
#(
  parameter int NCH = 16,
  localparam int CHW = $clog2(NCH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              arb_rr,
  input  logic [NCH-1:0]    sw_start,
  input  logic              cfg_we,
  input  logic [CHW-1:0]    cfg_ch,
  input  logic [1:0]        cfg_word,
  input  logic [31:0]       cfg_wdata,
  input  logic [NCH-1:0]    irq_clr,
  output logic [NCH-1:0]    irq,
  output logic              mem_req,
  output logic              mem_we,
  output logic [15:0]       mem_addr,
  output logic [31:0]       mem_wdata,
  input  logic [31:0]       mem_rdata,
  input  logic              mem_ack
);
  logic [1:0]     rsync_q;
  logic           rst_i;
  logic [NCH-1:0] pend_q, pend_n, irq_q, irq_n, clr_mask, link_mask;

  logic [ADDR_W-1:0] t_src [NCH];
  logic [ADDR_W-1:0] t_dst [NCH];
  logic [ADDR_W-1:0] t_nxt [NCH];
  logic [CNT_W-1:0]  t_nb  [NCH];
  logic [CNT_W-1:0]  t_cit [NCH];
  logic [LNK_W-1:0]  t_mlc [NCH];
  logic [LNK_W-1:0]  t_jlc [NCH];
  logic [NCH-1:0]    t_mle, t_jle, t_ie, t_sg;

  logic              gnt_vld, take, adv_src, adv_dst, minor_end, link_vld, irq_set, sg_wr;
  logic [CHW-1:0]    gnt_idx, cur;
  logic [LNK_W-1:0]  link_ch;
  logic [WIDX_W-1:0] sg_idx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= '0;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_i = rsync_q[1];

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    logic sel, wr_en;
    logic [WIDX_W-1:0] wr_idx;
    logic [DATA_W-1:0] wr_data;
    assign sel     = (cur == CHW'(g));
    assign wr_en   = sg_wr ? sel : (cfg_we && cfg_ch == CHW'(g));
    assign wr_idx  = sg_wr ? sg_idx : cfg_word;
    assign wr_data = sg_wr ? mem_rdata : cfg_wdata;
    dma_tcd u_tcd (
      .clk(clk), .rst_n(rst_i),
      .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
      .adv_src(adv_src && sel), .adv_dst(adv_dst && sel), .minor_end(minor_end && sel),
      .src(t_src[g]), .dst(t_dst[g]), .nbytes(t_nb[g]), .citer(t_cit[g]),
      .ml_en(t_mle[g]), .ml_ch(t_mlc[g]), .jl_en(t_jle[g]), .jl_ch(t_jlc[g]),
      .int_en(t_ie[g]), .sg_en(t_sg[g]), .nxt(t_nxt[g])
    );
    assign clr_mask[g]  = take && (gnt_idx == CHW'(g));
    assign link_mask[g] = link_vld && (link_ch[CHW-1:0] == CHW'(g));
  end

  always_comb begin
    pend_n = (pend_q & ~clr_mask) | sw_start | link_mask;
    irq_n  = (irq_q & ~irq_clr);
    if (irq_set) irq_n[cur] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) begin
      pend_q <= '0; irq_q <= '0;
    end else begin
      pend_q <= pend_n; irq_q <= irq_n;
    end
  end

  dma_arbiter #(.NCH(NCH)) u_arb (
    .clk(clk), .rst_n(rst_i), .req(pend_q), .rr_mode(arb_rr), .take(take),
    .gnt_vld(gnt_vld), .gnt_idx(gnt_idx)
  );

  dma_engine #(.NCH(NCH)) u_eng (
    .clk(clk), .rst_n(rst_i), .gnt_vld(gnt_vld), .gnt_idx(gnt_idx), .take(take), .cur(cur),
    .c_src(t_src[cur]), .c_dst(t_dst[cur]), .c_nbytes(t_nb[cur]), .c_citer(t_cit[cur]),
    .c_ml_en(t_mle[cur]), .c_ml_ch(t_mlc[cur]), .c_jl_en(t_jle[cur]), .c_jl_ch(t_jlc[cur]),
    .c_int_en(t_ie[cur]), .c_sg_en(t_sg[cur]), .c_nxt(t_nxt[cur]),
    .adv_src(adv_src), .adv_dst(adv_dst), .minor_end(minor_end),
    .link_vld(link_vld), .link_ch(link_ch), .irq_set(irq_set),
    .sg_wr(sg_wr), .sg_idx(sg_idx),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .mem_ack(mem_ack)
  );

  assign irq = irq_q;
endmodule

// File: rtl/dma_sched_chk.sv
module dma_sched_chk #(
  parameter int NCH = 16
) (
  input logic           clk,
  input logic           rst_n,
  input logic [NCH-1:0] irq,
  input logic [NCH-1:0] irq_clr,
  input logic           mem_req,
  input logic           mem_we,
  input logic [15:0]    mem_addr,
  input logic [31:0]    mem_wdata,
  input logic           mem_ack
);
  logic rd_seen_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rd_seen_q <= 1'b0;
    else if (mem_req && mem_ack) rd_seen_q <= !mem_we;
  end

  // R1: quiet bus in the first cycle after reset is released
  assert_idle_after_reset_R1: assert property (@(posedge clk)
    $rose(rst_n) |-> !mem_req);

  // R2: a pending request keeps its address, direction and data
  assert_req_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));

  // R2: a write is always preceded by a completed read
  assert_write_after_read_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we) |-> rd_seen_q);

  // R10: set interrupt bits survive unless cleared
  assert_irq_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((irq & $past(irq & ~irq_clr)) == $past(irq & ~irq_clr)));

  // R10: at most one interrupt bit rises per cycle
  assert_irq_single_rise_R10: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> $onehot0(irq & ~$past(irq)));
endmodule

bind dma_sched dma_sched_chk #(.NCH(NCH)) u_chk (
  .clk(clk), .rst_n(rst_n), .irq(irq), .irq_clr(irq_clr),
  .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
  .mem_wdata(mem_wdata), .mem_ack(mem_ack)
);

// File: tb/tb_dma_sched.sv
module tb_dma_sched;
  localparam int NCH = 16;

  logic           clk, rst_n, arb_rr, cfg_we, mem_req, mem_we, mem_ack;
  logic [NCH-1:0] sw_start, irq_clr, irq;
  logic [3:0]     cfg_ch;
  logic [1:0]     cfg_word;
  logic [31:0]    cfg_wdata, mem_wdata, mem_rdata;
  logic [15:0]    mem_addr;

  dma_sched #(.NCH(NCH)) dut (
    .clk(clk), .rst_n(rst_n), .arb_rr(arb_rr), .sw_start(sw_start),
    .cfg_we(cfg_we), .cfg_ch(cfg_ch), .cfg_word(cfg_word), .cfg_wdata(cfg_wdata),
    .irq_clr(irq_clr), .irq(irq), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ack(mem_ack)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  typedef struct packed { logic [15:0] a; logic [31:0] d; } wr_t;
  wr_t  exp_q[$];
  int   n_chk = 0, n_fail = 0;
  bit   done = 1'b0;
  logic [31:0] mem [256];
  logic [1:0]  stall_cnt;

  function automatic logic [31:0] img(int i);
    return 32'hA500_0000 ^ (32'(i) * 32'h0001_0203) ^ 32'(i);
  endfunction

  // memory model: stalls one cycle in four
  always_ff @(posedge clk) begin
    stall_cnt <= stall_cnt + 2'd1;
    if (mem_req && mem_we && mem_ack) mem[mem_addr[7:0]] <= mem_wdata;
  end
  assign mem_ack   = mem_req && (stall_cnt != 2'd3);
  assign mem_rdata = mem[mem_addr[7:0]];

  task automatic check(string tag, logic [47:0] act, logic [47:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && mem_req && mem_we && mem_ack) begin
      if (exp_q.size() == 0) begin
        check("R3 unexpected write", {mem_addr, mem_wdata}, 48'h0);
      end else begin
        wr_t e;
        e = exp_q.pop_front();
        check("R2 write addr/data", {mem_addr, mem_wdata}, {e.a, e.d});
      end
    end
  end

  task automatic push_loop(int src, int dst, int soff, int doff, int n);
    for (int i = 0; i < n; i++) begin
      wr_t e;
      e.a = 16'(dst + i * doff);
      e.d = img(src + i * soff);
      exp_q.push_back(e);
    end
  endtask

  task automatic cfg(int ch, int w, logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_ch = 4'(ch); cfg_word = 2'(w); cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic prog(int ch, int src, int dst, int soff, int doff, int nb, int cit,
                      logic [31:0] flags, int nxt);
    cfg(ch, 0, {16'(dst), 16'(src)});
    cfg(ch, 1, {8'(cit), 8'(nb), 8'(doff), 8'(soff)});
    cfg(ch, 2, flags);
    cfg(ch, 3, {16'h0, 16'(nxt)});
  endtask

  task automatic start(logic [NCH-1:0] m);
    @(negedge clk); sw_start = m;
    @(negedge clk); sw_start = '0;
  endtask

  task automatic wait_idle(string tag);
    int quiet = 0;
    int t = 0;
    while (quiet < 30 && t < 5000) begin
      @(negedge clk);
      if (mem_req) quiet = 0; else quiet++;
      t++;
    end
    check(tag, 48'(exp_q.size()), 48'h0);
  endtask

  // flag word: minor link ch[3:0] en[4], major link ch[11:8] en[12], int[16], sg[17]
  function automatic logic [31:0] fl(bit mle, int mlc, bit jle, int jlc, bit ie, bit sg);
    return {14'h0, sg, ie, 3'h0, jle, 4'(jlc), 3'h0, mle, 4'(mlc)};
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = img(i);
    // next descriptor for scatter/gather at 0x80 (R12 layout)
    mem[8'h80] = {16'h0060, 16'h0020};
    mem[8'h81] = {8'd1, 8'd2, 8'd1, 8'd1};
    mem[8'h82] = 32'h0001_0000;
    mem[8'h83] = 32'h0000_0090;
    stall_cnt = '0;
    rst_n = 1'b0; arb_rr = 1'b0; sw_start = '0; irq_clr = '0;
    cfg_we = 1'b0; cfg_ch = '0; cfg_word = '0; cfg_wdata = '0;
    repeat (4) @(negedge clk);
    check("R1 mem_req in reset", 48'(mem_req), 48'h0);
    check("R1 irq in reset", 48'(irq), 48'h0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 idle after reset", {47'h0, mem_req}, 48'h0);

    // R3/R4/R10: two-iteration major loop with interrupt
    prog(3, 'h10, 'h40, 1, 2, 3, 2, fl(0,0,0,0,1,0), 0);
    push_loop('h10, 'h40, 1, 2, 3);
    start(16'h0008);
    wait_idle("R3 first minor loop");
    check("R10 no irq mid major", 48'(irq), 48'h0);
    push_loop('h13, 'h46, 1, 2, 3);
    start(16'h0008);
    wait_idle("R3 second minor loop");
    check("R10 irq at major end", 48'(irq), 48'h0008);
    push_loop('h10, 'h40, 1, 2, 3);
    start(16'h0008);
    wait_idle("R4 reload after major");
    check("R10 irq sticky", 48'(irq), 48'h0008);
    @(negedge clk); irq_clr = 16'h0008;
    @(negedge clk); irq_clr = '0;
    @(negedge clk);
    check("R10 irq cleared", 48'(irq), 48'h0);

    // R3 negative offsets, R10 int disabled
    prog(5, 'h2F, 'h5F, -1, -1, 4, 1, fl(0,0,0,0,0,0), 0);
    push_loop('h2F, 'h5F, -1, -1, 4);
    start(16'h0020);
    wait_idle("R3 negative offsets");
    check("R10 no irq when disabled", 48'(irq), 48'h0);

    // R6 minor link 1 -> 2
    prog(2, 'h08, 'h58, 1, 1, 1, 8, fl(0,0,0,0,0,0), 0);
    prog(1, 'h00, 'h50, 1, 1, 2, 3, fl(1,2,0,0,0,0), 0);
    push_loop('h00, 'h50, 1, 1, 2);
    push_loop('h08, 'h58, 1, 1, 1);
    start(16'h0002);
    wait_idle("R6 minor link first");
    push_loop('h02, 'h52, 1, 1, 2);
    push_loop('h09, 'h59, 1, 1, 1);
    start(16'h0002);
    wait_idle("R6 minor link second");

    // R7 major link 1 -> 6, minor link to 2 suppressed
    prog(6, 'h30, 'h70, 1, 1, 1, 4, fl(0,0,0,0,0,0), 0);
    prog(1, 'h04, 'h54, 1, 1, 1, 1, fl(1,2,1,6,0,0), 0);
    push_loop('h04, 'h54, 1, 1, 1);
    push_loop('h30, 'h70, 1, 1, 1);
    start(16'h0002);
    wait_idle("R7 major link");

    // R8 fixed priority: 2, 10, 12 started together -> 12, 10, 2
    prog(10, 'h18, 'h62, 1, 1, 1, 8, fl(0,0,0,0,0,0), 0);
    prog(12, 'h19, 'h63, 1, 1, 1, 8, fl(0,0,0,0,0,0), 0);
    push_loop('h19, 'h63, 1, 1, 1);
    push_loop('h18, 'h62, 1, 1, 1);
    push_loop('h0A, 'h5A, 1, 1, 1);
    start(16'h1404);
    wait_idle("R8 fixed priority order");

    // R9 round robin: last grant 9, then 2, 10, 12 -> 10, 12, 2
    arb_rr = 1'b1;
    prog(9, 'h1A, 'h64, 1, 1, 1, 8, fl(0,0,0,0,0,0), 0);
    push_loop('h1A, 'h64, 1, 1, 1);
    start(16'h0200);
    wait_idle("R9 single grant");
    push_loop('h19, 'h63, 1, 1, 1);
    push_loop('h1A, 'h64, 1, 1, 1);
    push_loop('h0B, 'h5B, 1, 1, 1);
    start(16'h1404);
    wait_idle("R9 round robin order");
    arb_rr = 1'b0;

    // R11 scatter/gather reload from 0x80
    prog(7, 'h3A, 'h78, 1, 1, 1, 1, fl(0,0,0,0,0,1), 'h80);
    push_loop('h3A, 'h78, 1, 1, 1);
    start(16'h0080);
    wait_idle("R11 first descriptor");
    check("R10 no irq first descriptor", 48'(irq), 48'h0);
    push_loop('h20, 'h60, 1, 1, 2);
    start(16'h0080);
    wait_idle("R11 fetched descriptor");
    check("R11 fetched int enable", 48'(irq), 48'h0080);

    // R5 restart while running
    prog(4, 'h28, 'h74, 1, 1, 3, 4, fl(0,0,0,0,0,0), 0);
    push_loop('h28, 'h74, 1, 1, 6);
    start(16'h0010);
    repeat (2) @(negedge clk);
    start(16'h0010);
    wait_idle("R5 start while busy");

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule